// File: doc/BRIEF.md
# Memory Upset Test Sequencer

This block runs radiation upset tests on a dual-port memory. A test always starts by writing a known data pattern into every word. The pattern is computed from the address and a pattern select, so the block never holds a copy of the memory contents. After the write pass, the test runs in one of two modes:

- **Static mode.** The memory is left untouched for the whole exposure window. When `stop_i` arrives, every word is read back once and compared with the pattern.
- **Dynamic mode.** The block sweeps read-and-compare passes across the memory without a break, until it is told to stop.

Every failing word is counted as either a single-bit upset or a multi-bit upset. In dynamic mode, a failing word is written back with its expected value straight away. This means one upset is counted once, not on every later pass.

The memory is driven through one address bus, which carries either a write or a read in each cycle. Read data returns a fixed number of cycles (`RD_LAT`) after the read. The compare stage delays the address and valid flag by the same number of cycles, so each returning word meets the right expected value.

Top module: `mem_upset_seq`

## Requirements
- R1: On an accepted start, the block writes every address from 0 up to the last one, one address per cycle. Each word gets the pattern chosen by `pattern_i`, where bit i of the word is:
  - code 0: 0
  - code 1: 1
  - code 2: i[0] XOR addr[0]
  - code 3: addr[i mod ADDR_W]
- R2: In static mode, no write and no read reaches the memory between the end of the write pass and the `stop_i` pulse. After the pulse, each address is read exactly once, and then the test finishes.
- R3: In dynamic mode, reads sweep the addresses in ascending order again and again until a stop has been seen. The pass in progress is then completed, so every address has the same read count at the end.
- R4: A read is compared with the pattern when its data returns, `RD_LAT` cycles after the read. The number of set bits in the read data XOR the expected data decides the count:
  - exactly 1 increments `sbu_cnt_o` by one
  - 2 or more increments `mbu_cnt_o` by one
- R5: In dynamic mode, a failing word is rewritten with its expected value. In static mode, failing words are left as they are.
- R6: `sweep_cnt_o` counts completed read passes, so a static test ends with it at 1.
- R7: Start behaviour:
  - A start is accepted only while `busy_o` is low.
  - Acceptance clears all three counters and `done_o`, and raises `busy_o`.
  - At the end of the test, `busy_o` falls and `done_o` rises.
  - A start pulse while busy has no effect.
- R8: During and after reset, `busy_o`, `done_o`, `mem_we_o`, `mem_re_o` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a test (ignored while busy) |
| stop_i | input | 1 | End exposure (static) or end sweeping after the current pass (dynamic) |
| mode_i | input | 1 | 0 static, 1 dynamic; sampled at start |
| pattern_i | input | 2 | Pattern select; sampled at start |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | DATA_W | Memory read data, valid RD_LAT cycles after a read |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Last test has finished |
| sbu_cnt_o | output | CNT_W | Single-bit upset count |
| mbu_cnt_o | output | CNT_W | Multi-bit upset count |
| sweep_cnt_o | output | CNT_W | Completed read passes |

## Verification
- **Static tests.** These use the all-ones and address-derived patterns. Injected flips of one, two and three bits show whether the popcount classifier separates single-bit upsets from multi-bit upsets. Counting accesses during the exposure window shows whether the memory is left untouched.
- **Clean static run.** A static run with the address pattern and no flips checks the fill contents. It also shows that a correct pattern never produces a false error.
- **Dynamic test.** This uses the checkerboard pattern, with a single-bit flip and a double-bit flip injected mid-sweep. The counts tell apart a block that rewrites failing words (each flip counted once) from one that does not (each flip counted on every later pass). Per-address read counts show whether stop waits for the current pass to complete.

// File: rtl/upset_pkg.sv
package upset_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_EXPOSE,
    ST_READ,
    ST_DRAIN
  } seq_state_e;

  typedef enum logic [1:0] {
    PAT_ZERO    = 2'd0,
    PAT_ONE     = 2'd1,
    PAT_CHECKER = 2'd2,
    PAT_ADDR    = 2'd3
  } pat_e;
endpackage

// File: rtl/upset_patgen.sv
module upset_patgen
  import upset_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  pat_e              pat_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      unique case (pat_i)
        PAT_ZERO:    data_o[i] = 1'b0;
        PAT_ONE:     data_o[i] = 1'b1;
        PAT_CHECKER: data_o[i] = ((i % 2) == 1) ^ addr_i[0];
        default:     data_o[i] = addr_i[i % ADDR_W];
      endcase
    end
  end
endmodule

// File: rtl/upset_ctrl.sv
module upset_ctrl
  import upset_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic [1:0]        pattern_i,
  input  logic              fix_req_i,
  input  logic [ADDR_W-1:0] fix_addr_i,
  input  logic              inflight_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output pat_e              pat_o,
  output logic              dyn_o,
  output logic              clr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fill_o,
  output logic              expose_o,
  output logic [CNT_W-1:0]  sweep_cnt_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dyn_q, stop_q, done_q;
  pat_e              pat_q;
  logic [CNT_W-1:0]  sweep_q;

  assign clr_o    = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign fill_o   = (state_q == ST_FILL);
  assign expose_o = (state_q == ST_EXPOSE);
  assign pat_o    = pat_q;
  assign dyn_o    = dyn_q;
  assign sweep_cnt_o = sweep_q;

  always_comb begin
    mem_we_o   = 1'b0;
    mem_re_o   = 1'b0;
    mem_addr_o = addr_q;
    unique case (state_q)
      ST_FILL: mem_we_o = 1'b1;
      ST_READ: begin
        if (fix_req_i) begin
          mem_we_o   = 1'b1;
          mem_addr_o = fix_addr_i;
        end else begin
          mem_re_o = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (fix_req_i) begin
          mem_we_o   = 1'b1;
          mem_addr_o = fix_addr_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dyn_q   <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
      pat_q   <= PAT_ZERO;
      sweep_q <= '0;
    end else begin
      if (busy_o && stop_i) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_FILL;
            addr_q  <= '0;
            dyn_q   <= mode_i;
            pat_q   <= pat_e'(pattern_i);
            stop_q  <= 1'b0;
            done_q  <= 1'b0;
            sweep_q <= '0;
          end
        end
        ST_FILL: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST_ADDR) state_q <= dyn_q ? ST_READ : ST_EXPOSE;
        end
        ST_EXPOSE: begin
          if (stop_i || stop_q) state_q <= ST_READ;
        end
        ST_READ: begin
          if (!fix_req_i) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == LAST_ADDR) begin
              sweep_q <= sweep_q + 1'b1;
              if (!dyn_q || stop_i || stop_q) state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (!inflight_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upset_cmp.sv
module upset_cmp
  import upset_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  pat_e              pat_i,
  input  logic              dyn_i,
  output logic              fix_req_o,
  output logic [ADDR_W-1:0] fix_addr_o,
  output logic              inflight_o,
  output logic [CNT_W-1:0]  sbu_cnt_o,
  output logic [CNT_W-1:0]  mbu_cnt_o
);
  localparam int PC_W = $clog2(DATA_W + 1);

  logic [RD_LAT-1:0] v_q;
  logic [ADDR_W-1:0] a_q [RD_LAT];

  // address/valid delay line matched to memory read latency
  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[s] <= 1'b0;
        a_q[s] <= '0;
      end else if (s == 0) begin
        v_q[s] <= re_i;
        a_q[s] <= addr_i;
      end else begin
        v_q[s] <= v_q[(s == 0) ? 0 : s-1];
        a_q[s] <= a_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  logic [DATA_W-1:0] exp_data, diff;
  logic [PC_W-1:0]   ones;
  logic              hit_single, hit_multi;

  upset_patgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exp (
    .addr_i (a_q[RD_LAT-1]),
    .pat_i  (pat_i),
    .data_o (exp_data)
  );

  assign diff = rdata_i ^ exp_data;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + PC_W'(diff[i]);
  end

  assign hit_single = v_q[RD_LAT-1] && (ones == PC_W'(1));
  assign hit_multi  = v_q[RD_LAT-1] && (ones > PC_W'(1));
  assign fix_req_o  = dyn_i && (hit_single || hit_multi);
  assign fix_addr_o = a_q[RD_LAT-1];
  assign inflight_o = |v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbu_cnt_o <= '0;
      mbu_cnt_o <= '0;
    end else if (clr_i) begin
      sbu_cnt_o <= '0;
      mbu_cnt_o <= '0;
    end else begin
      if (hit_single) sbu_cnt_o <= sbu_cnt_o + 1'b1;
      if (hit_multi)  mbu_cnt_o <= mbu_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/mem_upset_seq.sv
module mem_upset_seq
  import upset_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic [1:0]        pattern_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  sbu_cnt_o,
  output logic [CNT_W-1:0]  mbu_cnt_o,
  output logic [CNT_W-1:0]  sweep_cnt_o
);
  pat_e              pat_w;
  logic              dyn_w, clr_w, fill_w, expose_w;
  logic              fix_req_w, inflight_w;
  logic [ADDR_W-1:0] fix_addr_w;

  upset_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .mode_i      (mode_i),
    .pattern_i   (pattern_i),
    .fix_req_i   (fix_req_w),
    .fix_addr_i  (fix_addr_w),
    .inflight_i  (inflight_w),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .pat_o       (pat_w),
    .dyn_o       (dyn_w),
    .clr_o       (clr_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fill_o      (fill_w),
    .expose_o    (expose_w),
    .sweep_cnt_o (sweep_cnt_o)
  );

  // write data for fill and for repair is the pattern at the driven address
  upset_patgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_pat (
    .addr_i (mem_addr_o),
    .pat_i  (pat_w),
    .data_o (mem_wdata_o)
  );

  upset_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_w),
    .re_i       (mem_re_o),
    .addr_i     (mem_addr_o),
    .rdata_i    (mem_rdata_i),
    .pat_i      (pat_w),
    .dyn_i      (dyn_w),
    .fix_req_o  (fix_req_w),
    .fix_addr_o (fix_addr_w),
    .inflight_o (inflight_w),
    .sbu_cnt_o  (sbu_cnt_o),
    .mbu_cnt_o  (mbu_cnt_o)
  );
endmodule

// File: rtl/mem_upset_seq_chk.sv
module mem_upset_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             mem_we_o,
  input logic             mem_re_o,
  input logic             fill_w,
  input logic             expose_w,
  input logic             dyn_w,
  input logic [CNT_W-1:0] sbu_cnt_o,
  input logic [CNT_W-1:0] mbu_cnt_o,
  input logic [CNT_W-1:0] sweep_cnt_o
);
  assert_one_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_quiet_expose_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expose_w |-> (!mem_we_o && !mem_re_o));

  assert_repair_dyn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !fill_w) |-> dyn_w);

  assert_sbu_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i && !busy_o) |->
      (sbu_cnt_o == $past(sbu_cnt_o) || sbu_cnt_o == $past(sbu_cnt_o) + 1'b1));

  assert_mbu_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i && !busy_o) |->
      (mbu_cnt_o == $past(mbu_cnt_o) || mbu_cnt_o == $past(mbu_cnt_o) + 1'b1));

  assert_sweep_mono_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i && !busy_o) |-> (sweep_cnt_o >= $past(sweep_cnt_o)));

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o));

  assert_start_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o && sbu_cnt_o == '0 && mbu_cnt_o == '0));
endmodule

bind mem_upset_seq mem_upset_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .fill_w      (fill_w),
  .expose_w    (expose_w),
  .dyn_w       (dyn_w),
  .sbu_cnt_o   (sbu_cnt_o),
  .mbu_cnt_o   (mbu_cnt_o),
  .sweep_cnt_o (sweep_cnt_o)
);

// File: tb/sim_mem_upset_seq.sv
module sim_mem_upset_seq;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int LAT   = 2;
  localparam int CW    = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, mode = 1'b0;
  logic [1:0] pattern = 2'd0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re, busy, done;
  logic [CW-1:0] sbu_cnt, mbu_cnt, sweep_cnt;

  always #4 clk = ~clk;

  mem_upset_seq #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .mode_i(mode),
    .pattern_i(pattern), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .sbu_cnt_o(sbu_cnt), .mbu_cnt_o(mbu_cnt),
    .sweep_cnt_o(sweep_cnt)
  );

  // behavioural memory with injection and access counting
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rpipe [LAT];
  int rd_cnt [DEPTH];
  int acc_cnt;
  logic inj_go = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_mask = '0;
  logic cnt_clr = 1'b0;

  assign mem_rdata = rpipe[LAT-1];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    rpipe[0] <= mem_re ? mem[mem_addr] : '0;
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
    if (cnt_clr) begin
      acc_cnt <= 0;
      for (int a = 0; a < DEPTH; a++) rd_cnt[a] <= 0;
    end else begin
      if (mem_we || mem_re) acc_cnt <= acc_cnt + 1;
      if (mem_re) rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] pat_word(input int a, input int p);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) begin
      case (p)
        0: w[i] = 1'b0;
        1: w[i] = 1'b1;
        2: w[i] = ((i % 2) != (a % 2));
        default: w[i] = ((a >> (i % AW)) & 1) != 0;
      endcase
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic inject(input int a, input logic [DW-1:0] m);
    @(negedge clk);
    inj_addr = AW'(a); inj_mask = m; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  task automatic pulse_start(input bit md, input int p);
    @(negedge clk);
    mode = md; pattern = 2'(p); start = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic check_fill(input int p, input string req);
    int bad = 0, first = -1;
    for (int a = 0; a < DEPTH; a++)
      if (mem[a] !== pat_word(a, p)) begin bad++; if (first < 0) first = a; end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R8 busy/done", {busy, done}, 0);
    chk(!mem_we && !mem_re, "R8 mem strobes", {mem_we, mem_re}, 0);
    chk(sbu_cnt == 0 && mbu_cnt == 0 && sweep_cnt == 0, "R8 counters",
        sbu_cnt + mbu_cnt + sweep_cnt, 0);
  endtask

  task automatic t_static_upsets();
    pulse_start(1'b0, 1);
    chk(busy && !done && sbu_cnt == 0, "R7 start accepted", {busy, done}, 2'b10);
    repeat (DEPTH + 4) @(negedge clk);
    check_fill(1, "R1 fill ones");
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    repeat (40) @(negedge clk);
    chk(acc_cnt == 0, "R2 quiet exposure", acc_cnt, 0);
    inject(3, 16'h0010);
    inject(10, 16'h0700);
    inject(20, 16'h8001);
    pulse_stop();
    wait_done();
    chk(done && !busy, "R7 done after static", {busy, done}, 2'b01);
    chk(sbu_cnt == 1, "R4 static single", sbu_cnt, 1);
    chk(mbu_cnt == 2, "R4 static multi", mbu_cnt, 2);
    chk(sweep_cnt == 1, "R6 static sweeps", sweep_cnt, 1);
    begin
      int bad = 0;
      for (int a = 0; a < DEPTH; a++) if (rd_cnt[a] != 1) bad++;
      chk(bad == 0, "R2 one read per address", bad, 0);
    end
    chk(mem[3] == (pat_word(3, 1) ^ 16'h0010), "R5 static no repair", mem[3],
        pat_word(3, 1) ^ 16'h0010);
  endtask

  task automatic t_static_clean();
    pulse_start(1'b0, 3);
    chk(!done && sbu_cnt == 0 && mbu_cnt == 0 && sweep_cnt == 0, "R7 start clears",
        sbu_cnt + mbu_cnt + sweep_cnt, 0);
    repeat (DEPTH + 4) @(negedge clk);
    check_fill(3, "R1 fill address pattern");
    pulse_stop();
    wait_done();
    chk(sbu_cnt == 0 && mbu_cnt == 0, "R4 no false errors", sbu_cnt + mbu_cnt, 0);
  endtask

  task automatic t_dynamic();
    pulse_start(1'b1, 2);
    repeat (DEPTH + 2) @(negedge clk);
    check_fill(2, "R1 fill checkerboard");
    repeat (20) @(negedge clk);
    inject(5, 16'h0004);
    inject(40, 16'h00C0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; // ignored while busy
    repeat (300) @(negedge clk);
    chk(busy && !done, "R3 still sweeping", {busy, done}, 2'b10);
    chk(sbu_cnt == 1, "R7 busy start ignored", sbu_cnt, 1);
    pulse_stop();
    wait_done();
    chk(done, "R3 dynamic ends", done, 1);
    chk(sbu_cnt == 1, "R5 single counted once", sbu_cnt, 1);
    chk(mbu_cnt == 1, "R4 dynamic multi", mbu_cnt, 1);
    chk(mem[5] == pat_word(5, 2), "R5 repair single", mem[5], pat_word(5, 2));
    chk(mem[40] == pat_word(40, 2), "R5 repair multi", mem[40], pat_word(40, 2));
    chk(sweep_cnt >= 3, "R6 dynamic sweeps", sweep_cnt, 3);
    begin
      int bad = 0;
      for (int a = 0; a < DEPTH; a++) if (rd_cnt[a] != int'(sweep_cnt)) bad++;
      chk(bad == 0, "R3 complete final pass", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_static_upsets();
    t_static_clean();
    t_dynamic();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule